// File: doc/BRIEF.md
# CAN Transmit Buffer Request Arbiter

This block keeps the request state, abort state and status flags for a small set of CAN transmit message buffers. The host loads each buffer's word, which carries a priority field and a payload, and then raises that buffer's request. A raised request only marks the buffer as ready. When the bus is reported free, a controller picks one eligible buffer and hands its index and word to a transmit engine through a one-cycle start pulse. The engine reports one outcome per attempt: delivered, lost arbitration or bus error. The block updates the buffer's request and flags from that outcome and raises the interrupt outputs.

A pending request can be withdrawn by a per-buffer cancel strobe, or for every buffer at once by a global abort strobe. If a buffer is idle, the cancel takes effect at once. If its frame is already on the bus, the cancel is held until the engine reports the outcome. A delivered frame stays delivered. A lost or failed frame is then dropped and marked aborted. A cancel cannot be withdrawn. While a request is pending, that buffer's word cannot be overwritten.

The controller has three states. `ST_IDLE` moves to `ST_LAUNCH` on the transition *launch*, taken when `bus_free` is high and at least one buffer is eligible. `ST_LAUNCH` always moves to `ST_BUSY` on the transition *hand-off*, and it drives `tx_start` for that one cycle. `ST_BUSY` returns to `ST_IDLE` on the transition *outcome*, taken when any engine outcome pulse arrives. Outcome pulses seen outside `ST_BUSY` are ignored.

Top module: `txb_arbiter`

## Requirements
- R1: Asserting `req_set[i]` raises `req_pend[i]` after one clock edge and sends nothing by itself. `tx_start` rises only in the cycle after a cycle in which `bus_free` was high. It lasts one cycle and comes with a pending buffer's index on `tx_idx` and that buffer's word on `tx_word`.
- R2: The buffer's priority is the top 2 bits of its word, and 3 is the most urgent. Among the eligible buffers the highest priority is launched. On a tie, the lowest index is launched.
- R3: A write to a buffer whose `req_pend` bit is high is ignored, and `host_rd_word` keeps returning the old word.
- R4: A rising `req_pend[i]` comes with `abort_flag[i]`, `larb_flag[i]` and `err_flag[i]` all cleared.
- R5: `eng_ok` clears the active buffer's request and sets its `txif` bit. `irq` is high when some buffer has both `txif` and `int_en` set. `txif_clr[i]` clears `txif[i]`.
- R6: `eng_lost` sets the active buffer's `larb_flag` and leaves its request pending, so it is tried again later.
- R7: `eng_err` sets the active buffer's `err_flag` and the shared `err_irq`, and leaves the request pending. `err_irq_clr` clears `err_irq`.
- R8: `req_clr[i]` on a pending buffer that is not on the bus clears the request and sets `abort_flag[i]` on the next edge. That buffer is never launched.
- R9: A cancel of the buffer on the bus takes effect at the outcome. After `eng_ok`, `txif` sets and `abort_flag` stays clear. After `eng_lost` or `eng_err`, the request clears and `abort_flag` sets, together with the matching failure flag.
- R10: A cancel cannot be withdrawn. A `req_set` of the buffer on the bus after its cancel has no effect. No input clears `abort_all_busy`.
- R11: `abort_all` raises `abort_all_busy` on the next edge. While it is high, every pending buffer that is not on the bus is aborted as in R8, and the buffer on the bus is handled as in R9.
- R12: `abort_all_busy` clears on the edge after a cycle in which no request is pending and no `req_set` or `abort_all` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host buffer-word write strobe |
| host_wr_idx | input | IDX_W | Buffer written |
| host_wr_word | input | PRIO_W+DATA_W | Word written: priority in the top bits, payload below |
| host_rd_idx | input | IDX_W | Buffer read back |
| host_rd_word | output | PRIO_W+DATA_W | Stored word of `host_rd_idx` |
| req_set | input | NBUF | Per-buffer request raise strobe |
| req_clr | input | NBUF | Per-buffer cancel strobe |
| abort_all | input | 1 | Global abort strobe |
| int_en | input | NBUF | Per-buffer transmit-interrupt enable |
| txif_clr | input | NBUF | Per-buffer transmit-interrupt flag clear |
| err_irq_clr | input | 1 | Error-interrupt flag clear |
| bus_free | input | 1 | Bus available for a new frame |
| tx_start | output | 1 | One-cycle launch pulse to the engine |
| tx_idx | output | IDX_W | Buffer on the bus |
| tx_word | output | PRIO_W+DATA_W | Word of the buffer on the bus |
| eng_ok | input | 1 | Engine: frame delivered |
| eng_lost | input | 1 | Engine: arbitration lost |
| eng_err | input | 1 | Engine: bus error during the frame |
| req_pend | output | NBUF | Pending-request bits |
| abort_flag | output | NBUF | Buffer aborted |
| larb_flag | output | NBUF | Buffer lost arbitration |
| err_flag | output | NBUF | Buffer hit a bus error |
| txif | output | NBUF | Transmit-complete flags |
| irq | output | 1 | Transmit interrupt |
| err_irq | output | 1 | Error interrupt flag |
| abort_all_busy | output | 1 | Global abort in force |

## Verification
The engine outcome and a cancel of the same buffer can fall in one cycle. The bench provokes this by pulsing `req_clr` on the buffer's index in the very cycle it drives `eng_ok`. It then does the same in the cycle it drives `eng_err`, and it also tries a cancel carried by `abort_all`. The judgement is made on the flags one edge later: with `eng_ok` the frame counts as delivered, `txif` is set and `abort_flag` stays clear. With `eng_err` or `eng_lost` the request clears and `abort_flag` sets together with the failure flag.

// File: rtl/txb_pkg.sv
package txb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } txb_state_e;

endpackage

// File: rtl/txb_slot.sv
// One transmit buffer: stored word, request, deferred cancel and status flags.
module txb_slot #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              cancel_i,
    input  logic              active_i,
    input  logic              ok_i,
    input  logic              lost_i,
    input  logic              err_i,
    input  logic              txif_clr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_word_i,
    output logic              req_o,
    output logic              abort_o,
    output logic              larb_o,
    output logic              err_o,
    output logic              txif_o,
    output logic [WORD_W-1:0] word_o
);

    logic              req_q;
    logic              wait_q;     // cancel held until the in-flight outcome
    logic              abort_q;
    logic              larb_q;
    logic              err_q;
    logic              txif_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            wait_q  <= 1'b0;
            abort_q <= 1'b0;
            larb_q  <= 1'b0;
            err_q   <= 1'b0;
            txif_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            // writes are locked out while a request is pending
            if (wr_en_i && !req_q) begin
                word_q <= wr_word_i;
            end
            if (txif_clr_i) begin
                txif_q <= 1'b0;
            end
            if (active_i) begin
                if (ok_i) begin
                    req_q  <= 1'b0;
                    txif_q <= 1'b1;
                    wait_q <= 1'b0;
                end else if (lost_i || err_i) begin
                    if (lost_i) larb_q <= 1'b1;
                    if (err_i)  err_q  <= 1'b1;
                    if (wait_q || cancel_i) begin
                        req_q   <= 1'b0;
                        abort_q <= 1'b1;
                        wait_q  <= 1'b0;
                    end
                end else if (cancel_i) begin
                    wait_q <= 1'b1;
                end
            end else if (req_q && cancel_i) begin
                req_q   <= 1'b0;
                abort_q <= 1'b1;
            end else if (set_i && !req_q) begin
                req_q   <= 1'b1;
                abort_q <= 1'b0;
                larb_q  <= 1'b0;
                err_q   <= 1'b0;
            end
        end
    end

    assign req_o   = req_q;
    assign abort_o = abort_q;
    assign larb_o  = larb_q;
    assign err_o   = err_q;
    assign txif_o  = txif_q;
    assign word_o  = word_q;

endmodule

// File: rtl/txb_pick.sv
// Highest priority wins; the strict compare keeps the lowest index on a tie.
module txb_pick #(
    parameter int NBUF   = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [NBUF-1:0]             elig_i,
    input  logic [NBUF-1:0][PRIO_W-1:0] prio_i,
    output logic                        any_o,
    output logic [IDX_W-1:0]            idx_o
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (elig_i[i] && (!any_o || (prio_i[i] > best))) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                best  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/txb_ctrl.sv
// Launch controller: IDLE -> LAUNCH -> BUSY -> IDLE.
module txb_ctrl
    import txb_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_free,
    input  logic             any_elig,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             eng_done,
    output logic [IDX_W-1:0] act_idx,
    output logic             tx_start,
    output logic             in_flight,
    output logic             outcome_en
);

    txb_state_e       state_q;
    txb_state_e       state_n;
    logic [IDX_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && state_n == ST_LAUNCH) begin
                act_q <= win_idx;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (bus_free && any_elig) state_n = ST_LAUNCH;
            ST_LAUNCH: state_n = ST_BUSY;
            ST_BUSY:   if (eng_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_start   = (state_q == ST_LAUNCH);
        in_flight  = (state_q != ST_IDLE);
        outcome_en = (state_q == ST_BUSY);
        act_idx    = act_q;
    end

endmodule

// File: rtl/txb_arbiter.sv
module txb_arbiter #(
    parameter int NBUF   = 4,
    parameter int PRIO_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  host_wr_en,
    input  logic [$clog2(NBUF)-1:0]               host_wr_idx,
    input  logic [PRIO_W+DATA_W-1:0]              host_wr_word,
    input  logic [$clog2(NBUF)-1:0]               host_rd_idx,
    output logic [PRIO_W+DATA_W-1:0]              host_rd_word,
    input  logic [NBUF-1:0]                       req_set,
    input  logic [NBUF-1:0]                       req_clr,
    input  logic                                  abort_all,
    input  logic [NBUF-1:0]                       int_en,
    input  logic [NBUF-1:0]                       txif_clr,
    input  logic                                  err_irq_clr,
    input  logic                                  bus_free,
    output logic                                  tx_start,
    output logic [$clog2(NBUF)-1:0]               tx_idx,
    output logic [PRIO_W+DATA_W-1:0]              tx_word,
    input  logic                                  eng_ok,
    input  logic                                  eng_lost,
    input  logic                                  eng_err,
    output logic [NBUF-1:0]                       req_pend,
    output logic [NBUF-1:0]                       abort_flag,
    output logic [NBUF-1:0]                       larb_flag,
    output logic [NBUF-1:0]                       err_flag,
    output logic [NBUF-1:0]                       txif,
    output logic                                  irq,
    output logic                                  err_irq,
    output logic                                  abort_all_busy
);

    localparam int IDX_W  = $clog2(NBUF);
    localparam int WORD_W = PRIO_W + DATA_W;

    logic [NBUF-1:0]             cancel;
    logic [NBUF-1:0]             elig;
    logic [NBUF-1:0]             active;
    logic [NBUF-1:0][PRIO_W-1:0] prio;
    logic [WORD_W-1:0]           words [NBUF];
    logic                        any_elig;
    logic [IDX_W-1:0]            win_idx;
    logic [IDX_W-1:0]            act_idx;
    logic                        in_flight;
    logic                        outcome_en;
    logic                        ok_g;
    logic                        lost_g;
    logic                        err_g;
    logic                        glob_q;
    logic                        err_irq_q;

    assign ok_g   = eng_ok   && outcome_en;
    assign lost_g = eng_lost && outcome_en;
    assign err_g  = eng_err  && outcome_en;

    assign cancel = req_clr | {NBUF{glob_q}};
    assign elig   = req_pend & ~cancel;

    generate
        for (genvar i = 0; i < NBUF; i++) begin : g_slot
            assign active[i] = in_flight && (act_idx == IDX_W'(i));
            assign prio[i]   = words[i][WORD_W-1 -: PRIO_W];

            txb_slot #(.WORD_W(WORD_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_i      (req_set[i]),
                .cancel_i   (cancel[i]),
                .active_i   (active[i]),
                .ok_i       (ok_g),
                .lost_i     (lost_g),
                .err_i      (err_g),
                .txif_clr_i (txif_clr[i]),
                .wr_en_i    (host_wr_en && (host_wr_idx == IDX_W'(i))),
                .wr_word_i  (host_wr_word),
                .req_o      (req_pend[i]),
                .abort_o    (abort_flag[i]),
                .larb_o     (larb_flag[i]),
                .err_o      (err_flag[i]),
                .txif_o     (txif[i]),
                .word_o     (words[i])
            );
        end
    endgenerate

    txb_pick #(.NBUF(NBUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .elig_i (elig),
        .prio_i (prio),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    txb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_free   (bus_free),
        .any_elig   (any_elig),
        .win_idx    (win_idx),
        .eng_done   (eng_ok || eng_lost || eng_err),
        .act_idx    (act_idx),
        .tx_start   (tx_start),
        .in_flight  (in_flight),
        .outcome_en (outcome_en)
    );

    // global abort: only the block itself ends it, once nothing is pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q    <= 1'b0;
            err_irq_q <= 1'b0;
        end else begin
            glob_q <= abort_all || (glob_q && ((|req_pend) || (|req_set)));
            if (err_irq_clr) err_irq_q <= 1'b0;
            if (err_g)       err_irq_q <= 1'b1;
        end
    end

    assign tx_idx         = act_idx;
    assign tx_word        = words[act_idx];
    assign host_rd_word   = words[host_rd_idx];
    assign irq            = |(txif & int_en);
    assign err_irq        = err_irq_q;
    assign abort_all_busy = glob_q;

endmodule

// File: rtl/txb_arbiter_chk.sv
module txb_arbiter_chk #(
    parameter int NBUF  = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_free,
    input logic             tx_start,
    input logic [IDX_W-1:0] tx_idx,
    input logic [NBUF-1:0]  req_pend,
    input logic [NBUF-1:0]  req_set,
    input logic [NBUF-1:0]  abort_flag,
    input logic [NBUF-1:0]  larb_flag,
    input logic [NBUF-1:0]  err_flag,
    input logic             abort_all,
    input logic             abort_all_busy
);

    // R1
    launch_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_free));

    // R1
    launch_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R1
    launch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> req_pend[tx_idx]);

    // R12
    glob_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_all_busy && (req_pend == '0) && (req_set == '0) && !abort_all)
            |=> !abort_all_busy);

    // R11
    glob_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_all |=> abort_all_busy);

    generate
        for (genvar i = 0; i < NBUF; i++) begin : g_buf
            // R4
            set_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_pend[i]) |-> (!abort_flag[i] && !larb_flag[i] && !err_flag[i]));

            // R8
            abort_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(abort_flag[i]) |-> !req_pend[i]);
        end
    endgenerate

endmodule

bind txb_arbiter txb_arbiter_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_free       (bus_free),
    .tx_start       (tx_start),
    .tx_idx         (tx_idx),
    .req_pend       (req_pend),
    .req_set        (req_set),
    .abort_flag     (abort_flag),
    .larb_flag      (larb_flag),
    .err_flag       (err_flag),
    .abort_all      (abort_all),
    .abort_all_busy (abort_all_busy)
);

// File: tb/txb_arbiter_tb.sv
module txb_arbiter_tb;

    localparam int NBUF   = 4;
    localparam int PRIO_W = 2;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 2;
    localparam int WORD_W = PRIO_W + DATA_W;
    localparam int K_OK = 0, K_LOST = 1, K_ERR = 2;

    // {request mask[13:10], prio b3..b0 [9:2], expected winner [1:0]}
    localparam int NVEC = 6;
    localparam logic [13:0] VEC [NVEC] = '{
        {4'b1111, 8'b00_00_00_00, 2'd0},
        {4'b1111, 8'b11_00_00_00, 2'd3},
        {4'b0110, 8'b00_10_01_00, 2'd2},
        {4'b1010, 8'b10_00_10_00, 2'd1},
        {4'b1100, 8'b01_01_00_11, 2'd2},
        {4'b0001, 8'b00_00_00_00, 2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr_en = 1'b0;
    logic [IDX_W-1:0]  host_wr_idx = '0;
    logic [WORD_W-1:0] host_wr_word = '0;
    logic [IDX_W-1:0]  host_rd_idx = '0;
    logic [WORD_W-1:0] host_rd_word;
    logic [NBUF-1:0]   req_set = '0;
    logic [NBUF-1:0]   req_clr = '0;
    logic              abort_all = 1'b0;
    logic [NBUF-1:0]   int_en = '1;
    logic [NBUF-1:0]   txif_clr = '0;
    logic              err_irq_clr = 1'b0;
    logic              bus_free = 1'b0;
    logic              tx_start;
    logic [IDX_W-1:0]  tx_idx;
    logic [WORD_W-1:0] tx_word;
    logic              eng_ok = 1'b0;
    logic              eng_lost = 1'b0;
    logic              eng_err = 1'b0;
    logic [NBUF-1:0]   req_pend;
    logic [NBUF-1:0]   abort_flag;
    logic [NBUF-1:0]   larb_flag;
    logic [NBUF-1:0]   err_flag;
    logic [NBUF-1:0]   txif;
    logic              irq;
    logic              err_irq;
    logic              abort_all_busy;

    int n_chk = 0;
    int n_fail = 0;
    logic [WORD_W-1:0] cap_word;

    always #4 clk = ~clk;

    txb_arbiter #(.NBUF(NBUF), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_word(host_wr_word),
        .host_rd_idx(host_rd_idx), .host_rd_word(host_rd_word),
        .req_set(req_set), .req_clr(req_clr), .abort_all(abort_all),
        .int_en(int_en), .txif_clr(txif_clr), .err_irq_clr(err_irq_clr),
        .bus_free(bus_free), .tx_start(tx_start), .tx_idx(tx_idx), .tx_word(tx_word),
        .eng_ok(eng_ok), .eng_lost(eng_lost), .eng_err(eng_err),
        .req_pend(req_pend), .abort_flag(abort_flag), .larb_flag(larb_flag),
        .err_flag(err_flag), .txif(txif), .irq(irq), .err_irq(err_irq),
        .abort_all_busy(abort_all_busy)
    );

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic write_word(input int b, input logic [WORD_W-1:0] w);
        host_wr_en = 1'b1; host_wr_idx = IDX_W'(b); host_wr_word = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic pulse_set(input logic [NBUF-1:0] m);
        req_set = m; @(negedge clk); req_set = '0;
    endtask

    task automatic pulse_clr(input logic [NBUF-1:0] m);
        req_clr = m; @(negedge clk); req_clr = '0;
    endtask

    // engine stub: wait for launch, optional cancel stimulus, then one outcome
    task automatic run_tx(input int kind, input bit pre_clr, input bit pre_set,
                          input bit pre_all, input bit same_clr, output int idx);
        idx = -1;
        for (int k = 0; k < 40 && !tx_start; k++) @(negedge clk);
        if (!tx_start) return;
        idx = int'(tx_idx);
        cap_word = tx_word;
        if (pre_clr || pre_all) begin
            if (pre_clr) req_clr[idx] = 1'b1;
            abort_all = pre_all;
            @(negedge clk);
            req_clr = '0; abort_all = 1'b0;
        end else begin
            @(negedge clk);
        end
        if (pre_set) begin
            req_set[idx] = 1'b1; @(negedge clk); req_set = '0;
        end
        eng_ok = (kind == K_OK); eng_lost = (kind == K_LOST); eng_err = (kind == K_ERR);
        if (same_clr) req_clr[idx] = 1'b1;
        @(negedge clk);
        eng_ok = 1'b0; eng_lost = 1'b0; eng_err = 1'b0; req_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int idx;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(req_pend == '0 && abort_flag == '0 && txif == '0, "R1 reset req/flags", int'(req_pend), 0);
        chk(!tx_start && !irq && !err_irq && !abort_all_busy, "R12 reset outputs", int'(tx_start), 0);

        // priority table
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] mask;
            logic [7:0] pr;
            int exp_i;
            mask = VEC[v][13:10]; pr = VEC[v][9:2]; exp_i = int'(VEC[v][1:0]);
            bus_free = 1'b0;
            for (int b = 0; b < NBUF; b++)
                write_word(b, {pr[2*b +: 2], 8'(16 * v + b)});
            pulse_set(mask);
            bus_free = 1'b1;
            run_tx(K_OK, 0, 0, 0, 0, idx);
            chk(idx == exp_i, "R2 winner", idx, exp_i);
            chk(cap_word == {pr[2*exp_i +: 2], 8'(16 * v + exp_i)}, "R1 tx_word",
                int'(cap_word), int'({pr[2*exp_i +: 2], 8'(16 * v + exp_i)}));
            for (int k = 0; k < NBUF && req_pend != '0; k++) run_tx(K_OK, 0, 0, 0, 0, idx);
            chk(req_pend == '0 && txif == mask, "R5 drained txif", int'(txif), int'(mask));
            txif_clr = '1; @(negedge clk); txif_clr = '0;
        end
        chk(txif == '0 && !irq, "R5 txif_clr", int'(txif), 0);

        // R1 / R3: pending buffer holds, write locked
        bus_free = 1'b0;
        write_word(0, 10'h0AA);
        pulse_set(4'b0001);
        chk(req_pend[0], "R1 request marked", int'(req_pend), 1);
        write_word(0, 10'h055);
        host_rd_idx = '0;
        #1 chk(host_rd_word == 10'h0AA, "R3 write ignored", int'(host_rd_word), 'h0AA);
        seen = 0;
        for (int k = 0; k < 4; k++) begin @(negedge clk); if (tx_start) seen = 1; end
        chk(!seen, "R1 no launch without bus_free", int'(seen), 0);

        // R8: cancel idle pending buffer
        pulse_clr(4'b0001);
        chk(!req_pend[0] && abort_flag[0], "R8 idle cancel", int'({req_pend[0], abort_flag[0]}), 1);
        bus_free = 1'b1;
        seen = 0;
        for (int k = 0; k < 5; k++) begin @(negedge clk); if (tx_start) seen = 1; end
        chk(!seen, "R8 aborted never launched", int'(seen), 0);

        // R4: new request clears the abort flag
        bus_free = 1'b0;
        pulse_set(4'b0001);
        chk(req_pend[0] && !abort_flag[0], "R4 abort flag cleared", int'(abort_flag), 0);
        pulse_clr(4'b0001);

        // R6: lost arbitration then retry
        bus_free = 1'b1;
        pulse_set(4'b0010);
        run_tx(K_LOST, 0, 0, 0, 0, idx);
        chk(larb_flag[1] && req_pend[1], "R6 lost keeps request", int'({larb_flag[1], req_pend[1]}), 3);
        run_tx(K_OK, 0, 0, 0, 0, idx);
        chk(idx == 1 && txif[1] && !req_pend[1], "R5 retry delivered", idx, 1);
        chk(irq, "R5 irq enabled", int'(irq), 1);
        txif_clr = 4'b0010; @(negedge clk); txif_clr = '0;
        chk(!irq, "R5 irq after clear", int'(irq), 0);

        // R7: error, then R4 on the error flag
        pulse_set(4'b0010);
        run_tx(K_ERR, 0, 0, 0, 0, idx);
        chk(err_flag[1] && err_irq && req_pend[1], "R7 error keeps request", int'({err_flag[1], err_irq, req_pend[1]}), 7);
        err_irq_clr = 1'b1; @(negedge clk); err_irq_clr = 1'b0;
        chk(!err_irq, "R7 err_irq clear", int'(err_irq), 0);
        run_tx(K_OK, 0, 0, 0, 0, idx);
        pulse_set(4'b0010);
        chk(!err_flag[1] && !larb_flag[1], "R4 error/larb flags cleared", int'({err_flag[1], larb_flag[1]}), 0);
        run_tx(K_OK, 0, 0, 0, 0, idx);
        txif_clr = '1; @(negedge clk); txif_clr = '0;

        // R9: cancel in flight, delivery wins; interrupt masked
        int_en = 4'b1011;
        pulse_set(4'b0100);
        run_tx(K_OK, 1, 0, 0, 0, idx);
        chk(txif[2] && !abort_flag[2] && !req_pend[2], "R9 delivered despite cancel", int'(abort_flag), 0);
        chk(!irq, "R5 irq masked by int_en", int'(irq), 0);

        // R10: cancel, then re-request, then lost -> still aborted
        pulse_set(4'b0100);
        run_tx(K_LOST, 1, 1, 0, 0, idx);
        chk(!req_pend[2] && abort_flag[2] && larb_flag[2], "R10 cancel not withdrawn",
            int'({req_pend[2], abort_flag[2], larb_flag[2]}), 3);

        // coincident cancel and outcome
        pulse_set(4'b1000);
        run_tx(K_OK, 0, 0, 0, 1, idx);
        chk(txif[3] && !abort_flag[3], "R9 same-cycle cancel with ok", int'(abort_flag[3]), 0);
        pulse_set(4'b1000);
        run_tx(K_ERR, 0, 0, 0, 1, idx);
        chk(!req_pend[3] && abort_flag[3] && err_flag[3], "R9 same-cycle cancel with error",
            int'({req_pend[3], abort_flag[3], err_flag[3]}), 3);
        err_irq_clr = 1'b1; txif_clr = '1; @(negedge clk); err_irq_clr = 1'b0; txif_clr = '0;

        // R11 / R12: global abort with nothing on the bus
        bus_free = 1'b0;
        pulse_set(4'b0011);
        abort_all = 1'b1; @(negedge clk); abort_all = 1'b0;
        chk(abort_all_busy && req_pend == 4'b0011, "R11 global abort raised", int'(req_pend), 3);
        @(negedge clk);
        chk(req_pend == '0 && abort_flag[1:0] == 2'b11 && abort_all_busy, "R11 all aborted",
            int'(abort_flag), 3);
        @(negedge clk);
        chk(!abort_all_busy, "R12 global abort released", int'(abort_all_busy), 0);

        // R11 with a frame on the bus
        bus_free = 1'b1;
        pulse_set(4'b0011);
        run_tx(K_OK, 0, 0, 1, 0, idx);
        chk(idx == 0 && txif[0] && !abort_flag[0], "R11 in-flight delivered", int'(abort_flag[0]), 0);
        chk(!req_pend[1] && abort_flag[1], "R11 waiting buffer aborted", int'(req_pend), 0);
        chk(abort_all_busy, "R12 busy held one more edge", int'(abort_all_busy), 1);
        @(negedge clk);
        chk(!abort_all_busy, "R12 released after flight", int'(abort_all_busy), 0);

        summary();
    end

endmodule